// File: doc/BRIEF.md
# Trigger-less Macropixel Readout Controller

This block reads out a binary pixel matrix without any trigger. The matrix is cut into square groups of pixels, here called tiles. Each tile ORs its pixel discriminator bits onto one line that runs to a per-tile capture slot. When that line goes high while the slot is free, the slot stores the tile's pixel bits and the present value of a free-running timestamp, and marks itself pending. Until its readout has finished, the slot ignores any further activity in its tile.

A token walks the slots in ascending tile index and wraps around, spending one cycle on each slot that is free. When the token reaches a pending slot it takes a copy of that slot's bits and timestamp. It then sends one output word for each fired pixel, lowest local pixel index first, over a valid/ready interface. After the last word of a tile is accepted, the slot is released and the token moves on. Back-pressure on the output holds the token where it is, and pending slots keep their contents meanwhile.

Top module: `pxr_top`

## Requirements
- R1: After reset `out_valid` is low and the timestamp is 0. Every pending tile and every partly sent tile is discarded, so a hit captured before the reset never reaches the output.
- R2: The pixel at matrix row r and column c (pix_hit bit r*COLS+c) belongs to tile (r/TILE)*(COLS/TILE)+(c/TILE) and has local index (r%TILE)*TILE+(c%TILE). TILE is a parameter: the default is 4 on a 32x8 matrix, and 2 on a 4x4 matrix is also valid.
- R3: When a free tile has at least one pixel high at a clock edge, it captures all of its pixel bits and the timestamp value present at that edge.
- R4: While a tile is pending, changes on its pixel inputs have no effect on what it later sends.
- R5: A captured tile yields exactly one word per fired pixel, in ascending local index. The word is {tile index, local index, timestamp}, with the timestamp in the low TS_W bits and the tile index in the top bits.
- R6: Pending tiles are served in ascending tile index starting from the token position. Tiles below the token are served after the wrap, so within one drain the tile index decreases at most once.
- R7: The timestamp is 0 after reset. It goes up by one on each clock edge at which `ts_tick` is high, and wraps modulo 2^TS_W.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged, and no word is lost.
- R9: Once the last word of a tile is accepted the tile is free again, and a later hit in that tile is captured with the new timestamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ts_tick | input | 1 | Timestamp advance enable |
| pix_hit | input | COLS*ROWS (256) | Pixel discriminator bits, bit r*COLS+c |
| out_ready | input | 1 | Downstream accepts a word |
| out_valid | output | 1 | Output word present |
| out_data | output | TILE_W+LOC_W+TS_W (16) | {tile index, local pixel index, timestamp} |

## Verification
The hardest case to reach from the ports is a tile that gets hit a second time while it is still frozen. The bench forces it by holding `out_ready` low so that the first capture cannot drain. It then fires other pixels in the same tile, waits, releases the stall, and checks that only the first pattern comes out. Arrival order across tiles depends on where the token happens to be when the hits land. For that reason the bench checks set membership plus a single-wrap ordering rule, and does not check exact cycles.

// File: rtl/pxr_pkg.sv
`timescale 1ns/1ps
package pxr_pkg;
  typedef enum logic {
    SCAN_HUNT  = 1'b0,
    SCAN_DRAIN = 1'b1
  } scan_st_t;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pxr_tile_slot.sv
`timescale 1ns/1ps
module pxr_tile_slot #(
  parameter int NLOC = 16,
  parameter int TS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLOC-1:0] pix_i,
  input  logic [TS_W-1:0] ts_i,
  input  logic            rel_i,
  output logic            pend_o,
  output logic [NLOC-1:0] bits_o,
  output logic [TS_W-1:0] ts_o
);
  logic            pend_q, pend_n;
  logic [NLOC-1:0] bits_q;
  logic [TS_W-1:0] tsc_q;
  logic            hit_or, cap_en;

  assign hit_or = |pix_i;
  assign cap_en = !pend_q && hit_or;

  always_comb begin
    pend_n = pend_q;
    if (pend_q && rel_i) pend_n = 1'b0;
    else if (cap_en)     pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      tsc_q  <= '0;
    end else if (cap_en) begin
      bits_q <= pix_i;
      tsc_q  <= ts_i;
    end
  end

  assign pend_o = pend_q;
  assign bits_o = bits_q;
  assign ts_o   = tsc_q;

  // R3
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && hit_or) |=> (pend_q && bits_q == $past(pix_i) && tsc_q == $past(ts_i)));
  // R4
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !rel_i) |=> (pend_q && $stable(bits_q) && $stable(tsc_q)));
endmodule

// File: rtl/pxr_scanner.sv
`timescale 1ns/1ps
module pxr_scanner
  import pxr_pkg::*;
#(
  parameter int NMP  = 16,
  parameter int NLOC = 16,
  parameter int TS_W = 8,
  localparam int MPI_W = idx_w(NMP),
  localparam int LOC_W = idx_w(NLOC),
  localparam int W     = MPI_W + LOC_W + TS_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NMP-1:0]            pend_i,
  input  logic [NMP-1:0][NLOC-1:0]  bits_i,
  input  logic [NMP-1:0][TS_W-1:0]  ts_i,
  input  logic                      out_ready,
  output logic                      out_valid,
  output logic [W-1:0]              out_data,
  output logic [NMP-1:0]            rel_o
);
  scan_st_t        st_q, st_n;
  logic [MPI_W-1:0] tok_q, tok_n, tok_inc;
  logic [NLOC-1:0]  left_q, left_n;
  logic [TS_W-1:0]  tsv_q, tsv_n;
  logic [LOC_W-1:0] sel;

  assign tok_inc = (tok_q == MPI_W'(NMP - 1)) ? '0 : tok_q + 1'b1;

  always_comb begin
    sel = '0;
    for (int i = NLOC - 1; i >= 0; i--) begin
      if (left_q[i]) sel = LOC_W'(i);
    end
  end

  always_comb begin
    st_n   = st_q;
    tok_n  = tok_q;
    left_n = left_q;
    tsv_n  = tsv_q;
    rel_o  = '0;
    case (st_q)
      SCAN_HUNT: begin
        if (pend_i[tok_q]) begin
          st_n   = SCAN_DRAIN;
          left_n = bits_i[tok_q];
          tsv_n  = ts_i[tok_q];
        end else begin
          tok_n = tok_inc;
        end
      end
      default: begin
        if (out_ready) begin
          left_n = left_q & ~(NLOC'(1) << sel);
          if (left_n == '0) begin
            st_n         = SCAN_HUNT;
            rel_o[tok_q] = 1'b1;
            tok_n        = tok_inc;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SCAN_HUNT;
      tok_q  <= '0;
      left_q <= '0;
      tsv_q  <= '0;
    end else begin
      st_q   <= st_n;
      tok_q  <= tok_n;
      left_q <= left_n;
      tsv_q  <= tsv_n;
    end
  end

  assign out_valid = (st_q == SCAN_DRAIN);
  assign out_data  = {tok_q, sel, tsv_q};

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R9
  release_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rel_o));
endmodule

// File: rtl/pxr_top.sv
`timescale 1ns/1ps
module pxr_top
  import pxr_pkg::*;
#(
  parameter int COLS = 32,
  parameter int ROWS = 8,
  parameter int TILE = 4,
  parameter int TS_W = 8,
  localparam int NPIX   = COLS * ROWS,
  localparam int TCOLS  = COLS / TILE,
  localparam int TROWS  = ROWS / TILE,
  localparam int NMP    = TCOLS * TROWS,
  localparam int NLOC   = TILE * TILE,
  localparam int TILE_W = idx_w(NMP),
  localparam int LOC_W  = idx_w(NLOC),
  localparam int W      = TILE_W + LOC_W + TS_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ts_tick,
  input  logic [NPIX-1:0] pix_hit,
  input  logic            out_ready,
  output logic            out_valid,
  output logic [W-1:0]    out_data
);
  logic                     rst_meta, rst_sync_n;
  logic [TS_W-1:0]          ts_q, ts_n;
  logic [NMP-1:0][NLOC-1:0] mp_pix, mp_bits;
  logic [NMP-1:0][TS_W-1:0] mp_ts;
  logic [NMP-1:0]           mp_pend, mp_rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign ts_n = ts_q + 1'b1;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ts_q <= '0;
    else if (ts_tick) ts_q <= ts_n;
  end

  for (genvar mr = 0; mr < TROWS; mr++) begin : g_trow
    for (genvar mc = 0; mc < TCOLS; mc++) begin : g_tcol
      localparam int M = mr * TCOLS + mc;
      for (genvar lr = 0; lr < TILE; lr++) begin : g_lrow
        for (genvar lc = 0; lc < TILE; lc++) begin : g_lcol
          assign mp_pix[M][lr*TILE+lc] = pix_hit[(mr*TILE+lr)*COLS + mc*TILE + lc];
        end
      end
      pxr_tile_slot #(.NLOC(NLOC), .TS_W(TS_W)) u_slot (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .pix_i  (mp_pix[M]),
        .ts_i   (ts_q),
        .rel_i  (mp_rel[M]),
        .pend_o (mp_pend[M]),
        .bits_o (mp_bits[M]),
        .ts_o   (mp_ts[M])
      );
    end
  end

  pxr_scanner #(.NMP(NMP), .NLOC(NLOC), .TS_W(TS_W)) u_scan (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pend_i    (mp_pend),
    .bits_i    (mp_bits),
    .ts_i      (mp_ts),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .rel_o     (mp_rel)
  );

  // R7
  ts_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ts_tick |=> (ts_q == TS_W'($past(ts_q) + 1'b1)));
  // R7
  ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ts_tick |=> $stable(ts_q));
  // R5
  word_from_pending_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> mp_pend[out_data[W-1 -: TILE_W]]);
endmodule

// File: tb/tb_pxr_top.sv
`timescale 1ns/1ps
module tb_pxr_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         tick;
  logic [255:0] pix;
  logic         ready;
  logic         out_valid;
  logic [15:0]  out_data;
  logic [15:0]  pix_s;
  logic         valid_s;
  logic [11:0]  data_s;

  int nvec = 0, nerr = 0, tcount = 0;
  logic [15:0] got[0:255];
  int ngot = 0;
  logic [11:0] got_s[0:15];
  int ngot_s = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pxr_top dut (
    .clk(clk), .rst_n(rst_n), .ts_tick(tick), .pix_hit(pix),
    .out_ready(ready), .out_valid(out_valid), .out_data(out_data)
  );

  pxr_top #(.COLS(4), .ROWS(4), .TILE(2), .TS_W(8)) dut_s (
    .clk(clk), .rst_n(rst_n), .ts_tick(1'b0), .pix_hit(pix_s),
    .out_ready(1'b1), .out_valid(valid_s), .out_data(data_s)
  );

  always @(negedge clk) begin
    if (rst_n && out_valid && ready && ngot < 256) begin
      got[ngot] = out_data;
      ngot = ngot + 1;
    end
    if (rst_n && valid_s && ngot_s < 16) begin
      got_s[ngot_s] = data_s;
      ngot_s = ngot_s + 1;
    end
  end

  function automatic logic [15:0] wrd(input int r, input int c, input int ts);
    logic [3:0] m, l;
    m = 4'((r / 4) * 8 + c / 4);
    l = 4'((r % 4) * 4 + c % 4);
    return {m, l, 8'(ts % 256)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pix = '0; pix_s = '0; tick = 1'b0; ready = 1'b1;
    cyc(2);
    rst_n = 1'b1;
    cyc(4);
    tcount = 0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    cyc(n);
    tick = 1'b0;
    tcount += n;
  endtask

  task automatic pulse();
    cyc(1);
    pix = '0;
  endtask

  task automatic setp(input int r, input int c);
    pix[r*32+c] = 1'b1;
  endtask

  task automatic t_reset();
    int base;
    do_reset();
    base = ngot;
    chk(out_valid == 1'b0, "R1 valid after reset", 32'(out_valid), 0);
    cyc(40);
    chk(ngot == base, "R1 no words after reset", 32'(ngot - base), 0);
  endtask

  task automatic t_single();
    int base = ngot;
    setp(2, 5);
    pulse();
    cyc(80);
    chk(ngot - base == 1, "R5 single count", 32'(ngot - base), 1);
    chk(got[base] == wrd(2, 5, tcount), "R2 R3 single word", 32'(got[base]), 32'(wrd(2, 5, tcount)));
  endtask

  task automatic t_multi();
    int base;
    ticks(7);
    base = ngot;
    setp(4, 8); setp(5, 9); setp(7, 11); setp(4, 11);
    pulse();
    cyc(80);
    chk(ngot - base == 4, "R5 multi count", 32'(ngot - base), 4);
    chk(got[base]   == wrd(4, 8, tcount),  "R5 order 0", 32'(got[base]),   32'(wrd(4, 8, tcount)));
    chk(got[base+1] == wrd(4, 11, tcount), "R5 order 1", 32'(got[base+1]), 32'(wrd(4, 11, tcount)));
    chk(got[base+2] == wrd(5, 9, tcount),  "R5 order 2", 32'(got[base+2]), 32'(wrd(5, 9, tcount)));
    chk(got[base+3] == wrd(7, 11, tcount), "R5 order 3", 32'(got[base+3]), 32'(wrd(7, 11, tcount)));
  endtask

  task automatic t_order();
    int base, desc, found;
    logic [15:0] e[4];
    ticks(3);
    base = ngot;
    e[0] = wrd(0, 4, tcount); e[1] = wrd(4, 12, tcount);
    e[2] = wrd(7, 31, tcount); e[3] = wrd(3, 0, tcount);
    setp(0, 4); setp(4, 12); setp(7, 31); setp(3, 0);
    pulse();
    cyc(80);
    chk(ngot - base == 4, "R6 count", 32'(ngot - base), 4);
    found = 0;
    for (int i = 0; i < 4; i++)
      for (int j = base; j < ngot; j++)
        if (got[j] == e[i]) found++;
    chk(found == 4, "R6 all tiles served", 32'(found), 4);
    desc = 0;
    for (int j = base + 1; j < ngot; j++)
      if (got[j][15:12] < got[j-1][15:12]) desc++;
    chk(desc <= 1, "R6 single wrap", 32'(desc), 1);
  endtask

  task automatic t_ts_wrap();
    int base;
    ticks(250);
    base = ngot;
    setp(6, 17);
    pulse();
    cyc(80);
    chk(ngot - base == 1, "R7 wrap count", 32'(ngot - base), 1);
    chk(got[base] == wrd(6, 17, tcount), "R7 wrapped ts", 32'(got[base]), 32'(wrd(6, 17, tcount)));
  endtask

  task automatic t_freeze();
    int base;
    logic [15:0] d0;
    base = ngot;
    ready = 1'b0;
    setp(0, 0);
    pulse();
    cyc(20);
    setp(0, 1); setp(1, 1);
    pulse();
    cyc(5);
    chk(out_valid == 1'b1, "R8 valid under stall", 32'(out_valid), 1);
    d0 = out_data;
    chk(d0 == wrd(0, 0, tcount), "R3 stalled word", 32'(d0), 32'(wrd(0, 0, tcount)));
    cyc(30);
    chk(out_valid == 1'b1 && out_data == d0, "R8 data stable", 32'(out_data), 32'(d0));
    ready = 1'b1;
    cyc(80);
    chk(ngot - base == 1, "R4 frozen count", 32'(ngot - base), 1);
    chk(got[base] == wrd(0, 0, tcount), "R4 frozen word", 32'(got[base]), 32'(wrd(0, 0, tcount)));
  endtask

  task automatic t_recapture();
    int base;
    ticks(2);
    base = ngot;
    setp(1, 1);
    pulse();
    cyc(80);
    chk(ngot - base == 1, "R9 recapture count", 32'(ngot - base), 1);
    chk(got[base] == wrd(1, 1, tcount), "R9 recapture word", 32'(got[base]), 32'(wrd(1, 1, tcount)));
  endtask

  task automatic t_reset_clear();
    int base;
    ticks(9);
    ready = 1'b0;
    setp(6, 20); setp(2, 2);
    pulse();
    cyc(10);
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(4);
    tcount = 0;
    base = ngot;
    ready = 1'b1;
    cyc(80);
    chk(ngot == base && out_valid == 1'b0, "R1 queue cleared", 32'(ngot - base), 0);
    setp(5, 30);
    pulse();
    cyc(80);
    chk(ngot - base == 1 && got[base] == wrd(5, 30, 0), "R1 R7 ts zero after reset",
        32'(got[base]), 32'(wrd(5, 30, 0)));
  endtask

  task automatic t_small();
    int base = ngot_s;
    pix_s[3*4+2] = 1'b1;
    cyc(1);
    pix_s = '0;
    cyc(40);
    chk(ngot_s - base == 1, "R2 small count", 32'(ngot_s - base), 1);
    chk(got_s[base] == {2'd3, 2'd2, 8'd0}, "R2 2x2 tile word", 32'(got_s[base]), 32'({2'd3, 2'd2, 8'd0}));
  endtask

  initial begin
    t_reset();
    t_single();
    t_multi();
    t_order();
    t_ts_wrap();
    t_freeze();
    t_recapture();
    t_small();
    t_reset_clear();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    #1600000;
    if (!done) begin
      done = 1'b1;
      nvec++;
      nerr++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule